// File: doc/BRIEF.md
# Regulator Target Voltage Ramp Stepper

This block sequences the digital output code of three on-chip regulator channels. Software writes a target code for a channel. When the target is above the code currently applied, the block raises the applied code by one step per programmable interval until it reaches the target. A lower or equal target takes effect at once, with no pacing. Each channel has its own 2-bit step-time selector, and all three selectors sit in one shared control word. A selector value n gives an interval of 64 << n reference-clock cycles, so the choices are 64, 128, 256 or 512 cycles. At the default selector value of 0 and a 24 MHz reference clock, one step lasts about 2.67 µs.

Each channel drives its applied code and a settled flag. The flag is high whenever the applied code equals the target. Software can therefore poll one bit instead of working out a worst-case delay from the selector and the code distance. The analog regulators are outside this block. So is whatever sets the selectors at boot, and so is the bus that carries the writes.

Top module: `vramp_stepper`

## Requirements
- R1: A synchronous reset, applied at any time, sets every applied code and every target code to 0 and every step-time selector to 0. After reset, all settled flags read 1.
- R2: After a target is written that is above the applied code, the applied code rises by exactly one per step. It takes (new − old) steps, ends equal to the target, and never changes by any other amount while no target write occurs.
- R3: Step k of a rising ramp appears at the applied output k × (64 << n) clock edges after the edge that captures the target write, where n is the channel's selector. Writes to address 0, 1 or 2 set the target of channel 0, 1 or 2 from data bits 4:0. A write to address 3 loads the selectors: channel 0 from bits 29:28, channel 1 from bits 27:26 and channel 2 from bits 25:24.
- R4: On the edge that captures a higher target, the applied code does not change and the settled flag goes low. The flag stays low until the applied code reaches the target.
- R5: A target lower than or equal to the applied code is copied to the applied output on the edge that captures the write. The settled flag stays high throughout.
- R6: Writing a new target during a ramp retargets from the applied code at that moment and restarts the step interval from the write edge.
- R7: Rewriting the selectors during a ramp changes the interval length for the steps that follow, without restarting the partly elapsed interval. Bits of the control word outside the three fields have no effect. A control write changes no applied code and no target.
- R8: A target write to one channel leaves the applied codes and settled flags of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | 0..2 selects a channel target, 3 selects the control word |
| wr_data | input | 32 | Write data: target in bits 4:0, selectors in bits 29:24 |
| applied | output | 3×5 | Applied code per channel, channel i in element i |
| settled | output | 3 | Per channel: applied code equals target |

## Verification
A wrong interval counter shows up as a step that lands early or late at the applied output. Every step is compared against its exact edge, so an error of one cycle is caught on the first step of the first ramp. A wrong target register or compare shows up as an extra step, a missing step, a downward write that does not take effect on its own edge, or a settled flag that stays set after a higher target is written. The scoreboard rejects any applied-code change it did not predict, so a disturbance of a channel that was not addressed is reported within the cycle it happens.

// File: rtl/vramp_pkg.sv
package vramp_pkg;

    localparam int unsigned DEF_NCH       = 3;
    localparam int unsigned DEF_CODE_W    = 5;
    localparam int unsigned DEF_FIELD_W   = 2;
    localparam int unsigned DEF_BASE_LOG2 = 6;
    localparam int unsigned DEF_ADDR_W    = 2;
    localparam int unsigned DEF_DATA_W    = 32;
    localparam int unsigned DEF_FIELD_TOP = 29;

    // number of reference cycles in one ramp step for a given selector
    function automatic int unsigned step_span(input int unsigned base_log2,
                                              input int unsigned sel);
        return 32'd1 << (base_log2 + sel);
    endfunction

endpackage

// File: rtl/vramp_steptime.sv
module vramp_steptime #(
    parameter int unsigned NCH       = 3,
    parameter int unsigned FIELD_W   = 2,
    parameter int unsigned FIELD_TOP = 29,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CTRL_ADDR = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [NCH-1:0][FIELD_W-1:0]   step_sel
);

    typedef struct packed {
        logic [NCH-1:0][FIELD_W-1:0] sel;
    } st_t;

    st_t st_d, st_q;
    logic ctrl_hit;

    assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    always_comb begin
        st_d = st_q;
        if (ctrl_hit) begin
            for (int i = 0; i < int'(NCH); i++) begin
                st_d.sel[i] = wr_data[FIELD_TOP - i*FIELD_W -: FIELD_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign step_sel = st_q.sel;

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_hit |=> $stable(step_sel)); // R7

endmodule

// File: rtl/vramp_channel.sv
module vramp_channel
    import vramp_pkg::*;
#(
    parameter int unsigned CODE_W    = 5,
    parameter int unsigned FIELD_W   = 2,
    parameter int unsigned BASE_LOG2 = 6,
    parameter int unsigned CNT_W     = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_hit,
    input  logic [CODE_W-1:0]  wr_code,
    input  logic [FIELD_W-1:0] step_sel,
    output logic [CODE_W-1:0]  applied,
    output logic               settled
);

    typedef struct packed {
        logic [CODE_W-1:0] tgt;
        logic [CODE_W-1:0] app;
        logic [CNT_W-1:0]  cnt;
    } ch_t;

    ch_t ch_d, ch_q;
    logic [CNT_W-1:0] cnt_last;

    assign cnt_last = CNT_W'(step_span(BASE_LOG2, 32'(step_sel)) - 32'd1);

    always_comb begin
        ch_d = ch_q;
        if (wr_hit) begin
            ch_d.tgt = wr_code;
            ch_d.cnt = '0;
            if (wr_code <= ch_q.app) begin
                ch_d.app = wr_code;
            end
        end else if (ch_q.app < ch_q.tgt) begin
            if (ch_q.cnt >= cnt_last) begin
                ch_d.app = ch_q.app + CODE_W'(1);
                ch_d.cnt = '0;
            end else begin
                ch_d.cnt = ch_q.cnt + CNT_W'(1);
            end
        end else begin
            ch_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ch_q <= '0;
        else     ch_q <= ch_d;
    end

    assign applied = ch_q.app;
    assign settled = (ch_q.app == ch_q.tgt);

    AST_DOWN_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wr_code <= applied) |=> (applied == $past(wr_code)) && settled); // R5

    AST_UP_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && wr_code > applied) |=> $stable(applied) && !settled); // R4

    AST_ONE_CODE_STEP: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> (applied == $past(applied)) || (applied == $past(applied) + CODE_W'(1))); // R2

    AST_SETTLED_STAYS: assert property (@(posedge clk) disable iff (rst)
        (settled && !wr_hit) |=> $stable(applied) && settled); // R2

endmodule

// File: rtl/vramp_stepper.sv
module vramp_stepper
    import vramp_pkg::*;
#(
    parameter int unsigned NCH       = DEF_NCH,
    parameter int unsigned CODE_W    = DEF_CODE_W,
    parameter int unsigned FIELD_W   = DEF_FIELD_W,
    parameter int unsigned BASE_LOG2 = DEF_BASE_LOG2,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned DATA_W    = DEF_DATA_W,
    parameter int unsigned FIELD_TOP = DEF_FIELD_TOP
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NCH-1:0][CODE_W-1:0]   applied,
    output logic [NCH-1:0]               settled
);

    localparam int unsigned CNT_W     = BASE_LOG2 + (1 << FIELD_W) - 1;
    localparam int unsigned CTRL_ADDR = NCH;

    logic [NCH-1:0][FIELD_W-1:0] step_sel;

    vramp_steptime #(
        .NCH       (NCH),
        .FIELD_W   (FIELD_W),
        .FIELD_TOP (FIELD_TOP),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) i_steptime (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .step_sel (step_sel)
    );

    for (genvar g = 0; g < int'(NCH); g++) begin : g_chan
        logic hit;
        assign hit = wr_en && (wr_addr == ADDR_W'(g));

        vramp_channel #(
            .CODE_W    (CODE_W),
            .FIELD_W   (FIELD_W),
            .BASE_LOG2 (BASE_LOG2),
            .CNT_W     (CNT_W)
        ) i_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_hit   (hit),
            .wr_code  (wr_data[CODE_W-1:0]),
            .step_sel (step_sel[g]),
            .applied  (applied[g]),
            .settled  (settled[g])
        );

        AST_OTHERS_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_addr != ADDR_W'(g) && settled[g]) |=> $stable(applied[g])); // R8
    end

endmodule

// File: tb/test_vramp_stepper.sv
module test_vramp_stepper;

    localparam int NCH = 3;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  wr_en = 1'b0;
    logic [1:0]            wr_addr = '0;
    logic [31:0]           wr_data = '0;
    logic [NCH-1:0][4:0]   applied;
    logic [NCH-1:0]        settled;

    vramp_stepper i_vramp_stepper (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .applied (applied),
        .settled (settled)
    );

    always #10 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int     ch;
        int     code;
        longint at;
    } exp_t;

    exp_t   sbq[$];
    int     cur[NCH];
    int     fld[NCH];
    int     prev[NCH];
    longint last_chg[NCH];
    int     total = 0;
    int     fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void push_exp(input int ch, input int code, input longint at);
        exp_t e;
        int   idx;
        e.ch = ch; e.code = code; e.at = at;
        idx = sbq.size();
        for (int i = 0; i < sbq.size(); i++) begin
            if (sbq[i].at > at) begin idx = i; break; end
        end
        sbq.insert(idx, e);
    endfunction

    function automatic void flush_ch(input int ch);
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].ch == ch) sbq.delete(i);
        end
    endfunction

    // monitor: every applied-code change must match the head of the queue
    initial begin
        for (int c = 0; c < NCH; c++) begin prev[c] = 0; cur[c] = 0; last_chg[c] = 0; end
        forever begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                if (rst) begin
                    prev[c] = int'(applied[c]);
                    cur[c]  = int'(applied[c]);
                end else if (int'(applied[c]) != prev[c]) begin
                    if (sbq.size() == 0) begin
                        chk(1'b0, "R8", $sformatf("unexpected change ch%0d", c),
                            longint'(applied[c]), longint'(prev[c]));
                    end else begin
                        chk(sbq[0].ch == c, "R2", "changing channel", c, sbq[0].ch);
                        chk(int'(applied[c]) == sbq[0].code, "R2", "step code",
                            longint'(applied[c]), sbq[0].code);
                        chk(cyc == sbq[0].at, "R3", "step edge", cyc, sbq[0].at);
                        void'(sbq.pop_front());
                    end
                    prev[c]     = int'(applied[c]);
                    cur[c]      = int'(applied[c]);
                    last_chg[c] = cyc;
                end
            end
        end
    end

    task automatic raw_write(input int addr, input logic [31:0] data, output longint w);
        @(negedge clk);
        #1;
        wr_en   = 1'b1;
        wr_addr = addr[1:0];
        wr_data = data;
        w       = cyc + 1;
        @(negedge clk);
        #1;
        wr_en   = 1'b0;
    endtask

    // driver: writes a target and schedules every expected step
    task automatic set_target(input int ch, input int code);
        longint w;
        longint span;
        @(negedge clk);
        #1;
        flush_ch(ch);
        wr_en   = 1'b1;
        wr_addr = ch[1:0];
        wr_data = 32'hFFFF_FFE0 | 32'(code);
        w       = cyc + 1;
        span    = 64 << fld[ch];
        if (code < cur[ch]) begin
            push_exp(ch, code, w);
        end else if (code > cur[ch]) begin
            for (int k = 1; k <= code - cur[ch]; k++) push_exp(ch, cur[ch] + k, w + k * span);
        end
        @(negedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_word();
        logic [31:0] v;
        v = 32'hC0FF_FFFF;
        for (int c = 0; c < NCH; c++) v[29 - 2*c -: 2] = fld[c][1:0];
        return v;
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 5000 && sbq.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R2", "pending steps", sbq.size(), 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        longint w;
        for (int c = 0; c < NCH; c++) fld[c] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int c = 0; c < NCH; c++) chk(applied[c] == 0, "R1", "reset applied", applied[c], 0);
        chk(settled == 3'b111, "R1", "reset settled", settled, 3'b111);

        // rising ramp at selector 0, other channels untouched
        set_target(0, 3);
        chk(settled[0] == 1'b0, "R4", "settled after up write", settled[0], 0);
        chk(applied[0] == 0, "R4", "applied on up write", applied[0], 0);
        chk(settled[2:1] == 2'b11, "R8", "other settled", settled[2:1], 2'b11);
        wait_idle();
        chk(applied[0] == 3 && settled[0], "R2", "ramp end ch0", applied[0], 3);

        // selector 1 on channel 1 (bits 27:26), junk in other bits
        fld[1] = 1;
        raw_write(3, ctrl_word(), w);
        chk(settled == 3'b111, "R7", "ctrl write settled", settled, 3'b111);
        set_target(1, 2);
        wait_idle();
        chk(applied[1] == 2, "R3", "ramp end ch1", applied[1], 2);

        // selectors 2 and 3
        fld[0] = 2; fld[2] = 3;
        raw_write(3, ctrl_word(), w);
        set_target(0, 5);
        wait_idle();
        chk(applied[0] == 5, "R3", "ramp end ch0 sel2", applied[0], 5);
        set_target(2, 1);
        wait_idle();
        chk(applied[2] == 1, "R3", "ramp end ch2 sel3", applied[2], 1);

        // downward and equal writes
        set_target(0, 1);
        chk(applied[0] == 1, "R5", "down applied", applied[0], 1);
        chk(settled[0] == 1'b1, "R5", "down settled", settled[0], 1);
        set_target(0, 1);
        chk(applied[0] == 1 && settled[0], "R5", "equal write", applied[0], 1);
        wait_idle();

        // retarget mid-ramp
        set_target(1, 6);
        repeat (200) @(negedge clk);
        chk(applied[1] == 3, "R6", "mid ramp code", applied[1], 3);
        set_target(1, 4);
        wait_idle();
        chk(applied[1] == 4 && settled[1], "R6", "retarget end", applied[1], 4);

        // selector rewrite mid-ramp on channel 2
        set_target(2, 3);
        for (int i = 0; i < 2000 && cur[2] != 2; i++) @(negedge clk);
        repeat (8) @(negedge clk);
        fld[2] = 0;
        raw_write(3, ctrl_word(), w);
        flush_ch(2);
        push_exp(2, 3, last_chg[2] + 64);
        wait_idle();
        chk(applied[2] == 3, "R7", "selector change end", applied[2], 3);

        // reset mid-operation restores defaults
        set_target(0, 9);
        repeat (20) @(negedge clk);
        #1;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        rst = 1'b0;
        sbq.delete();
        for (int c = 0; c < NCH; c++) fld[c] = 0;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) chk(applied[c] == 0, "R1", "re-reset applied", applied[c], 0);
        chk(settled == 3'b111, "R1", "re-reset settled", settled, 3'b111);
        set_target(1, 1);
        wait_idle();
        chk(applied[1] == 1, "R1", "selector back to 0", applied[1], 1);

        summary();
    end

endmodule